// File: doc/BRIEF.md
# Modem status change detector

This block watches four asynchronous modem control lines: clear-to-send (CTS), data-set-ready (DSR), ring indicator (RI) and carrier detect (DCD). Each line passes through its own synchronizer. The block shows the inverted level of every line in the upper half of an 8-bit status byte. In the lower half it keeps sticky change flags. A flag stays set until the status byte is read, and the OR of the flags is the modem interrupt request.

A per-line mode input says whether DSR, RI and DCD are in use as inputs. A line that is not an input reads 0 in its level bit and never raises its change flag. CTS is always treated as an input. A read is one cycle of `rd_strobe`. The status byte is always present on `rd_data`. A read clears the change flags at the clock edge that samples the strobe, so the byte seen during the strobe is the value from before the clear.

Top module: `modem_chg_detect`

## Requirements
- R1: `rd_data[7:4]` hold the inverted synchronized levels of DCD, RI, DSR and CTS, in that order from bit 7 down. `modem_lines` uses index 0=CTS, 1=DSR, 2=RI, 3=DCD. The CTS level bit is shown for every value of `pin_mode`.
- R2: `pin_mode` bit 1 (DSR), bit 2 (RI) and bit 3 (DCD) at 0 mark the line as not an input, and its level bit then reads 0. `pin_mode[0]` has no effect.
- R3: A line whose `pin_mode` bit is 0 never sets its change flag, whatever its pin does.
- R4: The change flags for CTS (`rd_data[0]`), DSR (`rd_data[1]`) and DCD (`rd_data[3]`) are set by a level change in either direction.
- R5: The RI change flag (`rd_data[2]`) is set only when the RI pin goes from high to low. A rising RI pin sets no flag.
- R6: A clock edge with `rd_strobe` high clears every change flag. While the strobe is high, `rd_data` shows the flags from before the clear. With no strobe, a set flag stays set.
- R7: A change event that reaches the flags at the same edge as a read leaves its own flag set after the read.
- R8: `modem_irq` is high exactly when at least one change flag is set.
- R9: Reset clears all change flags. After reset is released, no flag is raised by the line levels present at release, whatever those levels are.
- R10: A pin change that settles before a clock edge shows in its level bit after the second rising edge and in its change flag after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modem_lines | input | 4 | Raw modem lines: [0] CTS, [1] DSR, [2] RI, [3] DCD |
| pin_mode | input | 4 | 1 = line used as input; [1] DSR, [2] RI, [3] DCD; [0] unused |
| rd_strobe | input | 1 | One-cycle status read; clears the change flags |
| rd_data | output | 8 | Status byte: [7:4] inverted levels, [3:0] change flags |
| modem_irq | output | 1 | High while any change flag is set |

## Verification
The hardest case to reach from the ports is a new change event landing on the same clock edge as a read. The pin change has to be placed exactly three edges before the strobe. The bench drives DSR low on a falling edge and raises the strobe two edges later, with a CTS flag already pending. It then checks that the read cleared CTS and kept DSR. The bench also re-enables disabled lines only after their pins have returned to idle, and it resets the block with all lines held low, to show that re-enabling a line and releasing reset raise no false flags.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int LINES   = 4;
  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;
  localparam int STAT_W  = 2 * LINES;

  typedef logic [LINES-1:0] line_vec_t;

  // CTS is always an input; the mode bit for it is ignored.
  function automatic line_vec_t enable_mask(line_vec_t mode);
    return mode | line_vec_t'(1 << IDX_CTS);
  endfunction

  // Level view: inverted synchronized pin, gated by input enable.
  function automatic line_vec_t level_view(line_vec_t cur, line_vec_t en);
    return ~cur & en;
  endfunction

  // Change events: any toggle, except RI which counts falling edges only.
  function automatic line_vec_t change_events(line_vec_t cur, line_vec_t prev,
                                              line_vec_t en);
    line_vec_t toggled;
    line_vec_t fell;
    line_vec_t sel;
    toggled      = cur ^ prev;
    fell         = prev & ~cur;
    sel          = toggled;
    sel[IDX_RI]  = fell[IDX_RI];
    return sel & en;
  endfunction
endpackage

// File: rtl/mcd_sync.sv
module mcd_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '1;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/mcd_edge.sv
module mcd_edge
  import mcd_pkg::*;
#(
  parameter int WARM = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  line_vec_t cur,
  input  line_vec_t en,
  output line_vec_t evt
);
  localparam int CW = $clog2(WARM + 1);

  line_vec_t       hist_q;
  logic [CW-1:0]   warm_q;
  logic            armed;

  assign armed = (warm_q == CW'(WARM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '1;
      warm_q <= '0;
    end else begin
      hist_q <= cur;
      if (!armed) warm_q <= warm_q + CW'(1);
    end
  end

  // Until the synchronizer has filled, history just follows the input.
  assign evt = armed ? change_events(cur, hist_q, en) : '0;
endmodule

// File: rtl/mcd_flags.sv
module mcd_flags #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~{W{clr}}) | evt;
  end
endmodule

// File: rtl/modem_chg_detect.sv
module modem_chg_detect
  import mcd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  modem_lines,
  input  logic [LINES-1:0]  pin_mode,
  input  logic              rd_strobe,
  output logic [STAT_W-1:0] rd_data,
  output logic              modem_irq
);
  localparam int WARM = SYNC_STAGES + 1;

  line_vec_t line_sync;
  line_vec_t line_en;
  line_vec_t line_lvl;
  line_vec_t chg_evt;
  line_vec_t chg_flags;

  mcd_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (modem_lines),
    .q    (line_sync)
  );

  assign line_en  = enable_mask(pin_mode);
  assign line_lvl = level_view(line_sync, line_en);

  mcd_edge #(.WARM(WARM)) u_edge (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  (line_sync),
    .en   (line_en),
    .evt  (chg_evt)
  );

  mcd_flags #(.W(LINES)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (chg_evt),
    .clr  (rd_strobe),
    .flags(chg_flags)
  );

  assign rd_data   = {line_lvl, chg_flags};
  assign modem_irq = |chg_flags;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_strobe,
  input logic [3:0] pin_mode,
  input logic [7:0] rd_data,
  input logic       modem_irq,
  input logic [3:0] evt
);
  AST_DISABLED_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7:5] & ~pin_mode[3:1]) == 3'b000); // R2

  AST_DISABLED_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[3:1] & ~pin_mode[3:1]) == 3'b000); // R3

  AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((rd_data[3:0] & $past(evt)) == $past(evt))); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && evt == 4'b0000) |=> (rd_data[3:0] == 4'b0000)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0]))); // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!modem_irq && evt == 4'b0000) |=> !modem_irq); // R8
endmodule

bind modem_chg_detect mcd_checker u_mcd_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .rd_strobe(rd_strobe),
  .pin_mode (pin_mode),
  .rd_data  (rd_data),
  .modem_irq(modem_irq),
  .evt      (chg_evt)
);

// File: tb/test_modem_chg_detect.sv
`timescale 1ns/1ps
module test_modem_chg_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [3:0] lines = 4'hF;
  logic [3:0] mode = 4'hE;
  wire  [7:0] rd_data;
  wire        irq;
  int         n_checks = 0;
  int         n_errs = 0;

  always #2.5 clk = ~clk;

  modem_chg_detect i_modem_chg_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .modem_lines(lines),
    .pin_mode   (mode),
    .rd_strobe  (rd_strobe),
    .rd_data    (rd_data),
    .modem_irq  (irq)
  );

  // {lines[3:0] = DCD,RI,DSR,CTS ; mode[3:0] ; expected status byte}
  localparam int NV = 19;
  localparam logic [15:0] VEC [NV] = '{
    16'hEE11, // CTS falls: level + flag         R1 R4
    16'hFE01, // CTS rises: flag only             R4
    16'hDE22, // DSR falls                        R4
    16'hFE02, // DSR rises                        R4
    16'h7E88, // DCD falls                        R4
    16'hFE08, // DCD rises                        R4
    16'hBE44, // RI falls: flag                   R5
    16'hFE00, // RI rises: no flag                R5
    16'h7600, // DCD not input, pin low           R2 R3
    16'hF600, // DCD back high while disabled     R3
    16'hFE00, // re-enable DCD, idle              R3
    16'h9800, // DSR and RI not inputs, pins low  R2 R3
    16'hF800, // pins back high                   R3
    16'hFE00, // re-enable                        R3
    16'h0011, // all modes 0: CTS still seen      R1 R2
    16'hF001, // CTS rises                        R1
    16'hFE00, // restore mode                     R2
    16'h0EFF, // all lines fall together          R4 R5
    16'hFE0B  // all rise: RI raises no flag      R5
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_read();
    @(negedge clk) rd_strobe = 1'b1;
    @(negedge clk) rd_strobe = 1'b0;
  endtask

  task automatic wait_negs(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      6, 7:              return "R5 ri edge";
      8, 9, 10, 11, 12, 13: return "R2/R3 mode";
      14, 15, 16:        return "R1 cts always";
      17, 18:            return "R4/R5 group";
      default:           return "R4 toggle";
    endcase
  endfunction

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // Reset state: R9
    wait_negs(3);
    check("R9 flags in reset", {7'd0, irq}, 8'h00);
    check("R9 byte in reset", rd_data, 8'h00);
    rst_n = 1'b1;
    wait_negs(8);
    check("R9 after release", rd_data, 8'h00);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      lines = VEC[i][15:12];
      mode  = VEC[i][11:8];
      wait_negs(5);
      check(vec_tag(i), rd_data, VEC[i][7:0]);
      check("R8 irq", {7'd0, irq}, {7'd0, |VEC[i][3:0]});
      do_read();
      check("R6 cleared by read", {4'h0, rd_data[3:0]}, 8'h00);
      check("R8 irq after read", {7'd0, irq}, 8'h00);
    end

    // Latency: R10
    lines = 4'hE;
    wait_negs(1);
    check("R10 after 1 edge", rd_data, 8'h00);
    wait_negs(1);
    check("R10 level after 2 edges", rd_data, 8'h10);
    wait_negs(1);
    check("R10 flag after 3 edges", rd_data, 8'h11);

    // Flag stays without a read: R6
    wait_negs(6);
    check("R6 sticky", rd_data, 8'h11);

    // Event coincident with read: R7
    lines = 4'hC;            // DSR falls, CTS stays low
    wait_negs(2);            // level visible, flag due at next edge
    rd_strobe = 1'b1;
    check("R6 pre-clear value", rd_data, 8'h31);
    wait_negs(1);
    rd_strobe = 1'b0;
    check("R7 coincident event kept", rd_data, 8'h32);
    check("R8 irq on kept flag", {7'd0, irq}, 8'h01);

    lines = 4'hF;
    wait_negs(5);
    do_read();
    check("R6 clean after restore", rd_data, 8'h00);

    // Reset with all lines low: R9
    lines = 4'h0;
    rst_n = 1'b0;
    wait_negs(3);
    check("R9 reset clears flags", {4'h0, rd_data[3:0]}, 8'h00);
    rst_n = 1'b1;
    wait_negs(10);
    check("R9 no spurious flag", rd_data, 8'hF0);
    check("R9 irq low", {7'd0, irq}, 8'h00);

    finish_run();
  end
endmodule